// File: doc/BRIEF.md
# Flash command sequence interpreter

The block sits behind the write and read strobes of a small flash-style byte store. It watches each write (an address and a data byte) for keyed command sequences. Every sequence opens with two unlock writes. It recognises byte program, chip erase, sector erase, page erase, identification entry and exit, and two sizes of boot-region lockout. An accepted program or erase starts a timed internal operation on a behavioural byte array. While that operation runs, every read returns a status byte instead of array data. Any write that arrives during the operation is dropped.

The geometry scales with parameters. The top `SECT_BITS` address bits select a sector, and the next `PAGE_BITS` select a page inside it. The boot region is the top sector, or only its top quarter when the small lockout is chosen. The two unlock addresses are parameters. With the default 11-bit address they are 555h and 2AAh. Two pins guard the array: `top_guard_n` protects the top sector and `wr_guard_n` protects every other sector. Both pins override the software lockout state.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the block is not busy, is not in identification mode, and holds no software lockout. Every array byte reads FFh.
- R2: The sequence AAh@KEY_A, 55h@KEY_B, A0h@KEY_A followed by a write of D to address X starts a program operation. `busy` stays high for exactly PROG_CYCLES cycles. The byte at X then reads old & D, so programming only clears bits.
- R3: A write whose data or address does not match the next step of a sequence returns the matcher to idle and performs no operation. A later correct sequence is still accepted.
- R4: While `busy` is high, every write is ignored, including a complete command sequence.
- R5: The sequence AA/55, 80h@KEY_A, AA/55 then 30h to any address erases that sector to FFh. Ending instead with 50h erases the page holding the address. Bytes outside the region are unchanged. `busy` lasts one cycle per byte of the region.
- R6: Ending an erase sequence with 10h@KEY_A erases the whole array. Protected bytes keep their contents.
- R7: A read accepted while busy returns 0 in bits 5..0. Bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during an erase.
- R8: Bit 6 of the status byte is 0 on the first busy read after an operation starts. It inverts on each further busy read.
- R9: AA/55 then 90h@KEY_A enters identification mode. In that mode, address 0 reads DAh and address 1 reads 34h. The address that is all ones except 0Dh (7F2h by default) reads {4'b0, ~wr_guard_n, ~top_guard_n, small lock, large lock}. Every other address reads the array.
- R10: Identification mode ends either with AA/55 then F0h@KEY_A, or with a single F0h write to any address while the matcher is idle.
- R11: Ending an erase sequence with 40h@KEY_A locks the whole top sector. Ending it with 70h@KEY_A locks the top quarter of that sector. Program and erase are refused in a locked region, and the lock holds until reset.
- R12: While `top_guard_n` is low, program and sector or page erase are refused in the top sector. While `wr_guard_n` is low, they are refused in every other sector. A refused command never raises `busy`.
- R13: Read data appears on `rdata`, with `rd_valid` high, in the cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| top_guard_n | input | 1 | Low protects the top sector |
| wr_guard_n | input | 1 | Low protects every sector except the top one |
| rdata | output | 8 | Read result: array data, ID code or status |
| rd_valid | output | 1 | High in the cycle `rdata` carries a read result |
| busy | output | 1 | An internal program or erase is running |

## Verification
A write is taken at a rising edge, so `busy` can be seen high at the falling edge that follows the last command write. The bench counts falling edges from that point until `busy` drops. The count must be exactly PROG_CYCLES for a program and 16 for a page erase. Reads return at the falling edge one cycle after `rd_en` is driven. The driver queues each expected byte before raising the strobe, and the monitor pops the queue only at falling edges where `rd_valid` is high. Busy-time reads are issued right after the final command write, so each status byte is compared while the operation is certainly still running. Array contents are read back only after `busy` has fallen.

// File: rtl/fcc_pkg.sv
// Package: shared command codes, matcher states and read-source selector.
// Assumes: command bytes are 8 bits wide.
package fcc_pkg;

    localparam logic [7:0] CMD_KEY1      = 8'hAA;
    localparam logic [7:0] CMD_KEY2      = 8'h55;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_ERASE_PRE = 8'h80;
    localparam logic [7:0] CMD_ID_ENTER  = 8'h90;
    localparam logic [7:0] CMD_ID_LEAVE  = 8'hF0;
    localparam logic [7:0] CMD_CHIP      = 8'h10;
    localparam logic [7:0] CMD_SECTOR    = 8'h30;
    localparam logic [7:0] CMD_PAGE      = 8'h50;
    localparam logic [7:0] CMD_LOCK_BIG  = 8'h40;
    localparam logic [7:0] CMD_LOCK_SML  = 8'h70;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_E0, SQ_E1, SQ_E2, SQ_PG
    } seq_state_t;

    typedef enum logic [2:0] {
        RS_MEM, RS_STAT, RS_MFR, RS_DEV, RS_PROT
    } rd_src_t;

endpackage

// File: rtl/fcc_guard.sv
// Module: fcc_guard
// Decides from the top address bits whether a byte is write protected.
// Assumes: the top sector is the boot region. The small lock covers the top
// BOOT16_BITS-wide slice of that sector. Purely combinational.
module fcc_guard #(
    parameter int SECT_BITS   = 3,
    parameter int BOOT16_BITS = 2,
    localparam int TOP_W      = SECT_BITS + BOOT16_BITS
) (
    input  logic [TOP_W-1:0] top_bits,
    input  logic             top_guard_n,
    input  logic             wr_guard_n,
    input  logic             lock_big,
    input  logic             lock_small,
    output logic             locked
);
    logic in_top;
    logic in_small;

    // Region membership and the resulting protection verdict.
    always_comb begin
        in_top   = &top_bits[TOP_W-1 -: SECT_BITS];
        in_small = &top_bits;
        if (in_top) begin
            locked = !top_guard_n || lock_big || (lock_small && in_small);
        end else begin
            locked = !wr_guard_n;
        end
    end
endmodule

// File: rtl/fcc_matcher.sv
// Module: fcc_matcher
// Follows keyed command sequences write by write. It issues a start pulse
// with the operation range, and holds the identification mode and the
// software lock flags.
// Assumes: wr_en is already gated off while an operation is busy.
module fcc_matcher
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SECT_BITS   = 3,
    parameter int PAGE_BITS   = 4,
    parameter int BOOT16_BITS = 2,
    parameter logic [ADDR_W-1:0] KEY_A = 'h555,
    parameter logic [ADDR_W-1:0] KEY_B = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              top_guard_n,
    input  logic              wr_guard_n,
    output logic              start,
    output logic              start_erase,
    output logic [ADDR_W-1:0] range_lo,
    output logic [ADDR_W-1:0] range_hi,
    output logic [7:0]        prog_data,
    output logic              id_mode,
    output logic              lock_big,
    output logic              lock_small
);
    localparam int SECT_LOW = ADDR_W - SECT_BITS;
    localparam int PAGE_LOW = SECT_LOW - PAGE_BITS;
    localparam int TOP_W    = SECT_BITS + BOOT16_BITS;
    localparam logic [ADDR_W-1:0] SMASK = ADDR_W'((1 << SECT_LOW) - 1);
    localparam logic [ADDR_W-1:0] PMASK = ADDR_W'((1 << PAGE_LOW) - 1);

    seq_state_t        state_q, state_d;
    logic              id_set, id_clr, big_set, small_set;
    logic [ADDR_W-1:0] chk_addr;
    logic              chk_locked;
    logic              at_a, at_b;

    // Address whose protection decides whether the final write is accepted.
    always_comb begin
        if (state_q == SQ_PG) begin
            chk_addr = addr;
        end else if (wdata == CMD_PAGE) begin
            chk_addr = addr & ~PMASK;
        end else begin
            chk_addr = addr & ~SMASK;
        end
    end

    fcc_guard #(
        .SECT_BITS   (SECT_BITS),
        .BOOT16_BITS (BOOT16_BITS)
    ) u_guard (
        .top_bits    (chk_addr[ADDR_W-1 -: TOP_W]),
        .top_guard_n (top_guard_n),
        .wr_guard_n  (wr_guard_n),
        .lock_big    (lock_big),
        .lock_small  (lock_small),
        .locked      (chk_locked)
    );

    // Next-state and command decode for the incoming write.
    always_comb begin
        at_a        = (addr == KEY_A);
        at_b        = (addr == KEY_B);
        state_d     = state_q;
        start       = 1'b0;
        start_erase = 1'b0;
        range_lo    = addr;
        range_hi    = addr;
        prog_data   = wdata;
        id_set      = 1'b0;
        id_clr      = 1'b0;
        big_set     = 1'b0;
        small_set   = 1'b0;
        if (wr_en) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: begin
                    if (wdata == CMD_KEY1 && at_a) begin
                        state_d = SQ_K1;
                    end else if (wdata == CMD_ID_LEAVE) begin
                        id_clr = 1'b1;
                    end
                end
                SQ_K1: if (wdata == CMD_KEY2 && at_b) state_d = SQ_K2;
                SQ_K2: begin
                    if (at_a) begin
                        unique case (wdata)
                            CMD_PROGRAM:   state_d = SQ_PG;
                            CMD_ERASE_PRE: state_d = SQ_E0;
                            CMD_ID_ENTER:  id_set  = 1'b1;
                            CMD_ID_LEAVE:  id_clr  = 1'b1;
                            default:       state_d = SQ_IDLE;
                        endcase
                    end
                end
                SQ_E0: if (wdata == CMD_KEY1 && at_a) state_d = SQ_E1;
                SQ_E1: if (wdata == CMD_KEY2 && at_b) state_d = SQ_E2;
                SQ_E2: begin
                    unique case (wdata)
                        CMD_CHIP: begin
                            start       = at_a;
                            start_erase = 1'b1;
                            range_lo    = '0;
                            range_hi    = '1;
                        end
                        CMD_SECTOR: begin
                            start       = !chk_locked;
                            start_erase = 1'b1;
                            range_lo    = addr & ~SMASK;
                            range_hi    = addr | SMASK;
                        end
                        CMD_PAGE: begin
                            start       = !chk_locked;
                            start_erase = 1'b1;
                            range_lo    = addr & ~PMASK;
                            range_hi    = addr | PMASK;
                        end
                        CMD_LOCK_BIG: big_set   = at_a;
                        CMD_LOCK_SML: small_set = at_a;
                        default: ;
                    endcase
                end
                SQ_PG: start = !chk_locked;
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // Sequence state, identification mode and sticky software locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            id_mode    <= 1'b0;
            lock_big   <= 1'b0;
            lock_small <= 1'b0;
        end else begin
            state_q <= state_d;
            if (id_set) id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
            if (big_set) lock_big <= 1'b1;
            if (small_set) lock_small <= 1'b1;
        end
    end
endmodule

// File: rtl/fcc_engine.sv
// Module: fcc_engine
// Holds the byte array and runs the timed program or erase walk on it.
// Assumes: start arrives only while idle. An erase writes one byte per cycle
// from range_lo to range_hi and skips protected bytes.
module fcc_engine #(
    parameter int ADDR_W      = 11,
    parameter int SECT_BITS   = 3,
    parameter int BOOT16_BITS = 2,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] range_lo,
    input  logic [ADDR_W-1:0] range_hi,
    input  logic [7:0]        prog_data,
    input  logic              top_guard_n,
    input  logic              wr_guard_n,
    input  logic              lock_big,
    input  logic              lock_small,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              erase_run,
    output logic              prog_b7,
    output logic [7:0]        mem_q
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(PROG_CYCLES) + 1;
    localparam int TOP_W = SECT_BITS + BOOT16_BITS;

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] cur, hi_q;
    logic [7:0]        data_q;
    logic [CNT_W-1:0]  cnt;
    logic              cur_locked;

    fcc_guard #(
        .SECT_BITS   (SECT_BITS),
        .BOOT16_BITS (BOOT16_BITS)
    ) u_guard (
        .top_bits    (cur[ADDR_W-1 -: TOP_W]),
        .top_guard_n (top_guard_n),
        .wr_guard_n  (wr_guard_n),
        .lock_big    (lock_big),
        .lock_small  (lock_small),
        .locked      (cur_locked)
    );

    assign prog_b7 = data_q[7];

    // Array reads, operation launch, program countdown and erase walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            erase_run <= 1'b0;
            cur       <= '0;
            hi_q      <= '0;
            data_q    <= '0;
            cnt       <= '0;
            mem_q     <= 8'hFF;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            if (rd_en) mem_q <= mem[rd_addr];
            if (!busy && start) begin
                busy      <= 1'b1;
                erase_run <= start_erase;
                cur       <= range_lo;
                hi_q      <= range_hi;
                data_q    <= prog_data;
                cnt       <= CNT_W'(PROG_CYCLES - 1);
            end else if (busy) begin
                if (erase_run) begin
                    if (!cur_locked) mem[cur] <= 8'hFF;
                    if (cur == hi_q) busy <= 1'b0;
                    else cur <= cur + 1'b1;
                end else if (cnt == '0) begin
                    mem[cur] <= mem[cur] & data_q;
                    busy     <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fcc_readout.sv
// Module: fcc_readout
// Picks what a read returns: status while busy, ID or protection codes in
// identification mode, array data otherwise. Also owns the toggle bit.
// Assumes: mem_q is registered by the engine on the same rd_en edge.
module fcc_readout
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [7:0] MFR_CODE = 8'hDA,
    parameter logic [7:0] DEV_CODE = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              start,
    input  logic              erase_run,
    input  logic              prog_b7,
    input  logic              id_mode,
    input  logic              top_guard_n,
    input  logic              wr_guard_n,
    input  logic              lock_big,
    input  logic              lock_small,
    input  logic [7:0]        mem_q,
    output logic [7:0]        rdata,
    output logic              rd_valid
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ~ADDR_W'(13);

    rd_src_t    sel;
    logic [7:0] info_q;
    logic       tog;

    // Capture the read source and its side information at the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            sel      <= RS_MEM;
            info_q   <= '0;
            tog      <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (start && !busy) tog <= 1'b0;
            else if (rd_en && busy) tog <= ~tog;
            if (rd_en) begin
                if (busy) begin
                    sel    <= RS_STAT;
                    info_q <= {(erase_run ? 1'b0 : ~prog_b7), tog, 6'b0};
                end else if (id_mode && addr == '0) begin
                    sel <= RS_MFR;
                end else if (id_mode && addr == ADDR_W'(1)) begin
                    sel <= RS_DEV;
                end else if (id_mode && addr == STAT_ADDR) begin
                    sel    <= RS_PROT;
                    info_q <= {4'b0, ~wr_guard_n, ~top_guard_n, lock_small, lock_big};
                end else begin
                    sel <= RS_MEM;
                end
            end
        end
    end

    // Output mux over the captured source.
    always_comb begin
        unique case (sel)
            RS_STAT, RS_PROT: rdata = info_q;
            RS_MFR:           rdata = MFR_CODE;
            RS_DEV:           rdata = DEV_CODE;
            default:          rdata = mem_q;
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: flash_cmd_ctrl (top)
// Connects the command matcher, the timed array engine and the read mux.
// Assumes: one write or read per cycle, and writes are dropped while busy.
module flash_cmd_ctrl #(
    parameter int ADDR_W      = 11,
    parameter int SECT_BITS   = 3,
    parameter int PAGE_BITS   = 4,
    parameter int BOOT16_BITS = 2,
    parameter int PROG_CYCLES = 8,
    parameter logic [ADDR_W-1:0] KEY_A = 'h555,
    parameter logic [ADDR_W-1:0] KEY_B = 'h2AA,
    parameter logic [7:0] MFR_CODE = 8'hDA,
    parameter logic [7:0] DEV_CODE = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              top_guard_n,
    input  logic              wr_guard_n,
    output logic [7:0]        rdata,
    output logic              rd_valid,
    output logic              busy
);
    logic              wr_ok, start, start_erase, id_mode;
    logic              lock_big, lock_small, eng_erase, prog_b7;
    logic [ADDR_W-1:0] range_lo, range_hi;
    logic [7:0]        prog_data, mem_q;

    // Writes arriving during an operation never reach the matcher.
    assign wr_ok = wr_en && !busy;

    fcc_matcher #(
        .ADDR_W (ADDR_W), .SECT_BITS (SECT_BITS), .PAGE_BITS (PAGE_BITS),
        .BOOT16_BITS (BOOT16_BITS), .KEY_A (KEY_A), .KEY_B (KEY_B)
    ) u_matcher (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_ok), .addr (addr),
        .wdata (wdata), .top_guard_n (top_guard_n), .wr_guard_n (wr_guard_n),
        .start (start), .start_erase (start_erase), .range_lo (range_lo),
        .range_hi (range_hi), .prog_data (prog_data), .id_mode (id_mode),
        .lock_big (lock_big), .lock_small (lock_small)
    );

    fcc_engine #(
        .ADDR_W (ADDR_W), .SECT_BITS (SECT_BITS),
        .BOOT16_BITS (BOOT16_BITS), .PROG_CYCLES (PROG_CYCLES)
    ) u_engine (
        .clk (clk), .rst_n (rst_n), .start (start), .start_erase (start_erase),
        .range_lo (range_lo), .range_hi (range_hi), .prog_data (prog_data),
        .top_guard_n (top_guard_n), .wr_guard_n (wr_guard_n),
        .lock_big (lock_big), .lock_small (lock_small), .rd_en (rd_en),
        .rd_addr (addr), .busy (busy), .erase_run (eng_erase),
        .prog_b7 (prog_b7), .mem_q (mem_q)
    );

    fcc_readout #(
        .ADDR_W (ADDR_W), .MFR_CODE (MFR_CODE), .DEV_CODE (DEV_CODE)
    ) u_readout (
        .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .addr (addr), .busy (busy),
        .start (start), .erase_run (eng_erase), .prog_b7 (prog_b7),
        .id_mode (id_mode), .top_guard_n (top_guard_n), .wr_guard_n (wr_guard_n),
        .lock_big (lock_big), .lock_small (lock_small), .mem_q (mem_q),
        .rdata (rdata), .rd_valid (rd_valid)
    );
endmodule

// File: rtl/fcc_checker.sv
// Module: fcc_checker
// Temporal properties on the interface of flash_cmd_ctrl, attached by bind.
// Assumes: the same clock and synchronous reset as the top.
module fcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       busy,
    input logic       rd_valid,
    input logic [7:0] rdata,
    input logic       erase_run
);
    // R1: a reset cycle leaves the block idle with no read pending.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rd_valid));

    // R2: an operation only ever starts on an accepted write.
    assert_busy_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R7: status bytes carry zeros in their low six bits.
    assert_status_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy)) |-> (rdata[5:0] == 6'd0));

    // R7: an erase reports bit 7 low while it runs.
    assert_erase_poll_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy) && $past(erase_run)) |-> !rdata[7]);

    // R8: back-to-back busy reads return opposite bit 6 values.
    assert_toggle_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && $past(busy) && $past(busy, 2))
        |-> (rdata[6] != $past(rdata[6])));
endmodule

bind flash_cmd_ctrl fcc_checker u_fcc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rdata     (rdata),
    .erase_run (eng_erase)
);

// File: tb/flash_cmd_ctrl_bench.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module flash_cmd_ctrl_bench;
    localparam int ADDR_W      = 11;
    localparam int PROG_CYCLES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              top_guard_n = 1'b1;
    logic              wr_guard_n = 1'b1;
    logic [7:0]        rdata;
    logic              rd_valid;
    logic              busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_flash_cmd_ctrl (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .top_guard_n (top_guard_n),
        .wr_guard_n (wr_guard_n), .rdata (rdata), .rd_valid (rd_valid),
        .busy (busy)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: every returned read is compared with the oldest queued item (R13).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected read data", {8'h0, rdata}, 16'hFFFF);
            end else begin
                chk(tag_q.pop_front(), {8'h0, rdata}, {8'h0, exp_q.pop_front()});
            end
        end
    end

    // Tasks start and end at a falling edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        wr(11'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_cmd(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock();
        wr(11'h555, 8'h80);
        unlock();
        wr(a, d);
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        while (busy && k < 5000) begin
            @(negedge clk);
            k++;
        end
        if (busy) chk(tag, 16'd1, 16'd0);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 16'd1, 16'd0);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, erased array, normal mode; R13 read timing.
        chk("R1 busy after reset", {15'd0, busy}, 16'd0);
        rd(11'h010, 8'hFF, "R1 R13 array erased");
        rd(11'h000, 8'hFF, "R1 not in id mode");
        rd(11'h7F2, 8'hFF, "R1 status address reads array");

        // R2, R7, R8: program with busy-time status reads.
        prog(11'h010, 8'h3C);
        chk("R2 busy after program", {15'd0, busy}, 16'd1);
        rd(11'h010, 8'h80, "R7 program poll bit");
        rd(11'h010, 8'hC0, "R8 toggle second read");
        wait_idle("R2 program finishes");
        rd(11'h010, 8'h3C, "R2 programmed byte");
        prog(11'h011, 8'hA5);
        busy_len(n);
        chk("R2 program busy length", 16'(n), 16'(PROG_CYCLES));
        rd(11'h011, 8'hA5, "R2 second byte");
        prog(11'h010, 8'hF0);
        wait_idle("R2 reprogram");
        rd(11'h010, 8'h30, "R2 only clears bits");

        // R3: wrong data and wrong address abort a sequence.
        unlock();
        wr(11'h555, 8'h77);
        wr(11'h020, 8'h12);
        @(negedge clk);
        chk("R3 no busy after bad byte", {15'd0, busy}, 16'd0);
        rd(11'h020, 8'hFF, "R3 bad byte no program");
        wr(11'h555, 8'hAA);
        wr(11'h123, 8'h55);
        wr(11'h555, 8'hA0);
        wr(11'h020, 8'h00);
        wait_idle("R3 bad address");
        rd(11'h020, 8'hFF, "R3 bad address no program");
        prog(11'h020, 8'h5A);
        wait_idle("R3 recovery");
        rd(11'h020, 8'h5A, "R3 later sequence accepted");

        // R5, R7, R8, R4: sector erase with busy reads and ignored writes.
        prog(11'h100, 8'h00); wait_idle("R5 setup");
        prog(11'h0FF, 8'h00); wait_idle("R5 setup");
        erase_cmd(11'h1AB, 8'h30);
        chk("R5 busy after sector erase", {15'd0, busy}, 16'd1);
        rd(11'h1C0, 8'h00, "R7 erase poll bit");
        rd(11'h1C0, 8'h40, "R8 toggle during erase");
        prog(11'h300, 8'h00);
        wait_idle("R5 sector erase finishes");
        rd(11'h100, 8'hFF, "R5 sector low byte");
        rd(11'h1FF, 8'hFF, "R5 sector high byte");
        rd(11'h0FF, 8'h00, "R5 neighbour sector kept");
        rd(11'h300, 8'hFF, "R4 write during busy ignored");

        // R5: page erase and its busy length.
        prog(11'h230, 8'h00); wait_idle("R5 setup");
        prog(11'h240, 8'h00); wait_idle("R5 setup");
        erase_cmd(11'h235, 8'h50);
        busy_len(n);
        chk("R5 page erase busy length", 16'(n), 16'd16);
        rd(11'h230, 8'hFF, "R5 page erased");
        rd(11'h240, 8'h00, "R5 next page kept");

        // R9: identification mode codes and protection status.
        unlock(); wr(11'h555, 8'h90);
        rd(11'h000, 8'hDA, "R9 maker code");
        rd(11'h001, 8'h34, "R9 device code");
        rd(11'h7F2, 8'h00, "R9 status pins high");
        top_guard_n = 1'b0;
        rd(11'h7F2, 8'h04, "R9 status top pin low");
        wr_guard_n = 1'b0;
        rd(11'h7F2, 8'h0C, "R9 status both pins low");
        top_guard_n = 1'b1; wr_guard_n = 1'b1;
        rd(11'h020, 8'h5A, "R9 other address reads array");

        // R10: both exit forms.
        wr(11'h3AB, 8'hF0);
        rd(11'h000, 8'hFF, "R10 single write exit");
        unlock(); wr(11'h555, 8'h90);
        rd(11'h001, 8'h34, "R10 re-entered");
        unlock(); wr(11'h555, 8'hF0);
        rd(11'h001, 8'hFF, "R10 keyed exit");

        // R12: pin protection refuses commands.
        wr_guard_n = 1'b0;
        prog(11'h050, 8'h00);
        chk("R12 refused program not busy", {15'd0, busy}, 16'd0);
        rd(11'h050, 8'hFF, "R12 low sector protected");
        wr_guard_n = 1'b1; top_guard_n = 1'b0;
        prog(11'h7F0, 8'h00);
        chk("R12 refused top program not busy", {15'd0, busy}, 16'd0);
        rd(11'h7F0, 8'hFF, "R12 top sector protected");
        prog(11'h050, 8'h00);
        wait_idle("R12 open sector");
        rd(11'h050, 8'h00, "R12 other sectors open");
        top_guard_n = 1'b1;

        // R11, R6: small lock, then chip erase skipping the locked bytes.
        prog(11'h7D0, 8'h11); wait_idle("R11 setup");
        erase_cmd(11'h555, 8'h70);
        unlock(); wr(11'h555, 8'h90);
        rd(11'h7F2, 8'h02, "R11 small lock reported");
        wr(11'h000, 8'hF0);
        prog(11'h7F8, 8'h00);
        chk("R11 locked program not busy", {15'd0, busy}, 16'd0);
        rd(11'h7F8, 8'hFF, "R11 small region protected");
        prog(11'h780, 8'h00); wait_idle("R11 outside small region");
        rd(11'h780, 8'h00, "R11 rest of top sector open");
        erase_cmd(11'h555, 8'h10);
        wait_idle("R6 chip erase finishes");
        rd(11'h7D0, 8'h11, "R6 locked byte kept");
        rd(11'h780, 8'hFF, "R6 top sector rest erased");
        rd(11'h050, 8'hFF, "R6 low byte erased");
        rd(11'h020, 8'hFF, "R6 other byte erased");

        // R11: large lock covers the whole top sector.
        erase_cmd(11'h555, 8'h40);
        unlock(); wr(11'h555, 8'h90);
        rd(11'h7F2, 8'h03, "R11 both locks reported");
        wr(11'h000, 8'hF0);
        prog(11'h700, 8'h00);
        chk("R11 large lock refuses", {15'd0, busy}, 16'd0);
        rd(11'h700, 8'hFF, "R11 top sector protected");

        repeat (3) @(negedge clk);
        chk("R13 all reads returned", 16'(exp_q.size()), 16'd0);
        finish_run();
    end
endmodule